// File: doc/BRIEF.md
# Periodic Compare Timer with Sleep Gating

This block is a up-counting timer that produces a periodic interrupt request. A counter starts at zero and advances by one on each counting step. When the counter holds the programmed compare value at a step, it returns to zero on that step and sets a capture flag. The interrupt request output follows the flag, but only while the interrupt enable bit is set. The flag stays set until software clears it by writing a one.

The counting step comes from one of three sources, chosen by a tick-select field:
- every pulse of a base tick input;
- every second pulse of that tick;
- an external tick input.

A power-state input can pause counting. In the active and idle states the timer counts whenever it is enabled. In standby it counts only if the standby-run bit is set. In power-down it never counts. With this gating the timer can go on waking a sleeping system from standby. A simple register port writes the control word, the compare value and the flag, and reads them back together with the live count.

Top module: `wake_timer`

## Requirements
- R1: After synchronous reset the following are all zero: the control word, the compare value, the capture flag, the count and `irq_o`.
- R2: On each counting step the count rises by one. If the count equals the compare value at a step, the next count is 0 and the capture flag is set on that same edge. The period is therefore compare+1 steps. With a constant base tick and divide-by-1, `irq_o` first rises compare+2 cycles after the enabling write.
- R3: `irq_o` is a register loaded with (capture flag AND control bit 4, the interrupt enable). It therefore follows the flag one cycle later, and it stays low while bit 4 is 0 even when the flag is set.
- R4: The capture flag is bit 0 at address 2. Writing 1 there clears it. Writing 0 there has no effect. A flag set in the same cycle as a clear takes priority over the clear.
- R5: While control bit 0 (run) is 0, the count holds its value.
- R6: In sleep_state 0 (active) and 1 (idle), an enabled timer counts.
- R7: In sleep_state 2 (standby), the count holds unless control bit 1 (standby-run) is 1.
- R8: In sleep_state 3 (power-down), the count holds whatever control bit 1 is.
- R9: Control bits [3:2] select the step source:
  - 0: every cycle with `tick_in` high.
  - 1: every second `tick_in` pulse; the first step comes on the second pulse after reset.
  - 2: every cycle with `ext_tick` high.
  - 3: behaves as 0.
- R10: The register map is as follows. Address 0 is the control word, bits [4:0]. Address 1 is the compare value. Address 2 is the flag. Address 3 is the read-only count. `rd_data` returns the register at `rd_addr` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Base tick enable |
| ext_tick | input | 1 | External tick enable |
| sleep_state | input | 2 | 0 active, 1 idle, 2 standby, 3 power-down |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | CNT_W | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with the default 16-bit counter. It programs small compare values (2, 3, 4, 9), which makes the wrap to zero, the first-interrupt latency and the divide-by-2 phase reachable within a few dozen cycles. A compare value of 0xFFFF keeps wraps out of the way while the power-state and enable gating are measured as count differences over five-cycle windows.

// File: rtl/wake_timer_pkg.sv
package wake_timer_pkg;
  typedef enum logic [1:0] {
    SLP_ACTIVE    = 2'd0,
    SLP_IDLE      = 2'd1,
    SLP_STANDBY   = 2'd2,
    SLP_POWERDOWN = 2'd3
  } slp_e;

  typedef enum logic [1:0] {
    TSEL_DIV1 = 2'd0,
    TSEL_DIV2 = 2'd1,
    TSEL_EXT  = 2'd2,
    TSEL_RSVD = 2'd3
  } tsel_e;

  // packed MSB first: bit4 irq_en, bits3:2 tsel, bit1 stby_run, bit0 run
  typedef struct packed {
    logic  irq_en;
    tsel_e tsel;
    logic  stby_run;
    logic  run;
  } ctrl_t;

  localparam int CTRL_W = 5;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_CMP  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_FLAG = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_CNT  = 2'd3;
endpackage

// File: rtl/wt_regs.sv
module wt_regs
  import wake_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              hit,
  input  logic [CNT_W-1:0]  cnt,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              flag_o,
  output logic [CNT_W-1:0]  rd_data
);
  localparam int PAD_CTRL = CNT_W - CTRL_W;
  localparam int PAD_FLAG = CNT_W - 1;

  logic clr_req;
  assign clr_req = wr_en && (wr_addr == ADR_FLAG) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o <= '0;
      cmp_o  <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADR_CTRL) ctrl_o <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_addr == ADR_CMP)  cmp_o  <= wr_data;
    end
  end

  // set has priority over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst)          flag_o <= 1'b0;
    else if (hit)     flag_o <= 1'b1;
    else if (clr_req) flag_o <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        ADR_CTRL: rd_data <= {{PAD_CTRL{1'b0}}, ctrl_o};
        ADR_CMP:  rd_data <= cmp_o;
        ADR_FLAG: rd_data <= {{PAD_FLAG{1'b0}}, flag_o};
        default:  rd_data <= cnt;
      endcase
    end
  end

  AST_FLAG_FROM_HIT: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(hit)); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !hit) |=> !flag_o); // R4
  AST_HIT_WINS: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag_o); // R4
endmodule

// File: rtl/wt_gate.sv
module wt_gate
  import wake_timer_pkg::*;
(
  input  logic run,
  input  logic stby_run,
  input  slp_e sleep,
  output logic allow
);
  always_comb begin
    case (sleep)
      SLP_ACTIVE, SLP_IDLE: allow = run;
      SLP_STANDBY:          allow = run && stby_run;
      default:              allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/wt_tick_sel.sv
module wt_tick_sel
  import wake_timer_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  allow,
  input  tsel_e tsel,
  input  logic  tick_in,
  input  logic  ext_tick,
  output logic  step
);
  logic phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else if (allow && tick_in && tsel == TSEL_DIV2) phase <= ~phase;
  end

  always_comb begin
    case (tsel)
      TSEL_DIV2: step = allow && tick_in && phase;
      TSEL_EXT:  step = allow && ext_tick;
      default:   step = allow && tick_in;
    endcase
  end

  AST_DIV2_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
    (tsel == TSEL_DIV2 && step && $stable(tsel)) |=> !(step && tsel == TSEL_DIV2)); // R9
endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  assign hit = step && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (hit)  cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    hit |=> (cnt == '0)); // R2
  AST_STEP_INCR: assert property (@(posedge clk) disable iff (rst)
    (step && !hit) |=> (cnt == $past(cnt) + 1'b1)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt)); // R5
endmodule

// File: rtl/wake_timer.sv
module wake_timer
  import wake_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_in,
  input  logic             ext_tick,
  input  logic [1:0]       sleep_state,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] cmp;
  logic [CNT_W-1:0] cnt;
  logic             flag;
  logic             hit;
  logic             allow;
  logic             step;
  slp_e             sleep;

  assign sleep = slp_e'(sleep_state);

  wt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .hit(hit), .cnt(cnt), .ctrl_o(ctrl), .cmp_o(cmp),
    .flag_o(flag), .rd_data(rd_data)
  );

  wt_gate u_gate (
    .run(ctrl.run), .stby_run(ctrl.stby_run), .sleep(sleep), .allow(allow)
  );

  wt_tick_sel u_tick (
    .clk(clk), .rst(rst), .allow(allow), .tsel(ctrl.tsel),
    .tick_in(tick_in), .ext_tick(ext_tick), .step(step)
  );

  wt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .cmp(cmp), .cnt(cnt), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= flag && ctrl.irq_en;
  end

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ctrl.irq_en)); // R3
  AST_RUN_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctrl.run |=> $stable(cnt)); // R5
  AST_STBY_HALT: assert property (@(posedge clk) disable iff (rst)
    (sleep == SLP_STANDBY && !ctrl.stby_run) |=> $stable(cnt)); // R7
  AST_PD_HALT: assert property (@(posedge clk) disable iff (rst)
    (sleep == SLP_POWERDOWN) |=> $stable(cnt)); // R8
endmodule

// File: tb/sim_wake_timer.sv
module sim_wake_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tick_in = 1'b1;
  logic             ext_tick = 1'b0;
  logic [1:0]       sleep_state = 2'd0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [1:0]       rd_addr = '0;
  logic [CNT_W-1:0] rd_data;
  logic             irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_timer #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .tick_in(tick_in), .ext_tick(ext_tick),
    .sleep_state(sleep_state), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
  );

  localparam logic [15:0] C_RUN  = 16'h0001;
  localparam logic [15:0] C_STBY = 16'h0002;
  localparam logic [15:0] C_IE   = 16'h0010;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick_in = 1'b1; ext_tick = 1'b0; sleep_state = 2'd0;
    wr_en = 1'b0; rd_addr = 2'd0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  // count difference over five clock edges, rd_addr held on the count
  task automatic diff5(output int d);
    logic [15:0] a;
    rd_addr = 2'd3;
    @(negedge clk);
    @(negedge clk);
    a = rd_data;
    repeat (5) @(negedge clk);
    d = int'(rd_data - a);
  endtask

  task automatic t_reset_and_map();
    logic [15:0] v;
    do_reset();
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check($sformatf("R1 reset addr %0d", a), v, 0);
    end
    check("R1 irq after reset", irq_o, 0);
    wr(2'd1, 16'h1234);
    wr(2'd0, 16'h001A);
    rd(2'd1, v);
    check("R10 compare readback", v, 16'h1234);
    rd(2'd0, v);
    check("R10 control readback", v, 16'h001A);
  endtask

  task automatic t_period(input logic [15:0] cmp, input logic [1:0] sel,
                          input int exp_lat, input string tag);
    int n;
    do_reset();
    wr(2'd1, cmp);
    wr(2'd0, C_RUN | C_IE | (16'(sel) << 2));
    n = 0;
    while (!irq_o && n < 300) begin
      @(negedge clk);
      n++;
    end
    check(tag, n, exp_lat);
  endtask

  task automatic t_gating();
    int d;
    do_reset();
    wr(2'd1, 16'hFFFF);
    wr(2'd0, C_RUN);
    sleep_state = 2'd0; diff5(d); check("R6 active counts", d, 5);
    sleep_state = 2'd1; diff5(d); check("R6 idle counts", d, 5);
    sleep_state = 2'd2; diff5(d); check("R7 standby halts by default", d, 0);
    wr(2'd0, C_RUN | C_STBY);
    diff5(d); check("R7 standby-run counts", d, 5);
    sleep_state = 2'd3; diff5(d); check("R8 power-down halts", d, 0);
    sleep_state = 2'd0;
    wr(2'd0, C_STBY);
    diff5(d); check("R5 run off holds", d, 0);
  endtask

  task automatic t_ext();
    int d;
    logic [15:0] v;
    do_reset();
    wr(2'd1, 16'hFFFF);
    wr(2'd0, C_RUN | (16'd2 << 2));
    diff5(d); check("R9 ext source ignores tick_in", d, 0);
    rd(2'd3, v);
    @(negedge clk); ext_tick = 1'b1;
    repeat (3) @(negedge clk);
    ext_tick = 1'b0;
    @(negedge clk);
    rd(2'd3, v);
    check("R9 ext source three pulses", v, 3);
  endtask

  task automatic t_flag();
    logic [15:0] v;
    do_reset();
    wr(2'd1, 16'd2);
    wr(2'd0, C_RUN);
    repeat (10) @(negedge clk);
    check("R3 irq masked when enable clear", irq_o, 0);
    rd(2'd2, v);
    check("R2 flag set after match", v, 1);
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h0000);
    rd(2'd2, v);
    check("R4 writing 0 keeps flag", v, 1);
    wr(2'd0, C_IE);
    @(negedge clk);
    check("R3 irq follows flag once enabled", irq_o, 1);
    wr(2'd2, 16'h0001);
    @(negedge clk);
    rd(2'd2, v);
    check("R4 write 1 clears flag", v, 0);
    check("R3 irq drops after clear", irq_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_and_map();
    t_period(16'd4, 2'd0, 6,  "R2 period cmp=4 div1");
    t_period(16'd9, 2'd3, 11, "R9 encoding 3 as div1 cmp=9");
    t_period(16'd3, 2'd1, 9,  "R9 div2 cmp=3");
    t_gating();
    t_ext();
    t_flag();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule